// File: doc/BRIEF.md
# Per-CPU Banked Level Interrupt Mask Aggregator

This block gathers a parameterised set of level-sensitive interrupt lines, organised as N_WORDS words of 32 lines each, and produces one interrupt request per CPU. Every CPU owns a private register bank holding its own mask state. A CPU's request is raised whenever some line is high and is unmasked in that CPU's bank. No line is latched: the status view always shows the present input levels.

Software changes masks only through two write-one ports per word, one that disables lines and one that enables them. No read-modify-write is ever needed, so two CPUs, or two handlers on one CPU, cannot corrupt each other's updates. A single memory-mapped port, with a bank select, reaches all banks. Reads return data one clock after the request.

Inside a bank, four groups of N_WORDS registers follow one another in this order: the live status, the current mask, the disable port and the enable port. A register's byte offset is (group × N_WORDS + word) × 4, so one bank spans 16 bytes per word.

Top module: `irq_banked_aggregator`

## Requirements
- R1: After reset every mask bit in every bank is 1 (line disabled), every CPU request is 0 and no read response is valid.
- R2: The byte offset of a register is (group × N_WORDS + word) × 4, where group 0 is status, 1 is mask state, 2 is the disable port and 3 is the enable port. Address bits [1:0] are ignored.
- R3: Writing the disable port (group 2) sets to 1 each mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Writing the enable port (group 3) clears to 0 each mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: A read of status word w returns source lines [32w+31:32w] as they are in the request cycle, with no latching.
- R6: A CPU's request output is the OR over all words of (source AND NOT mask) in its bank, registered, so it lags a change of sources or masks by one clock.
- R7: Banks are independent. A write to the bank selected by the CPU index changes no other bank's mask, and a line reaches a CPU only if that CPU's bank enables it.
- R8: Writes to the status and mask-state groups have no effect. Reads of the disable and enable groups return 0.
- R9: A read request produces a response valid pulse and data exactly one clock later. Cycles without a read request produce no response valid.
- R10: An access at byte offset 16 × N_WORDS or above, or to a bank index of N_CPUS or above, reads 0 and changes no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_cpu_i | input | CPU_W | Bank (CPU) select |
| bus_addr_i | input | ADDR_W | Byte offset within the bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one clock after the read request |
| bus_rdata_o | output | 32 | Read data |
| src_i | input | N_WORDS×32 | Level-sensitive interrupt lines |
| cpu_irq_o | output | N_CPUS | Per-CPU interrupt request |

## Verification
A mask write takes effect at the clock edge that accepts it, and the CPU request reflects that change one edge later. A change of source level likewise appears on the request after one edge. Read data and its valid flag arrive one edge after the request edge. The bench drives inputs on falling edges. Its driver queues each expected read word at the request, and a monitor pops the queue at the next falling edge, exactly when the valid flag must be high. Request outputs are compared with a bench-side mask model only after the one extra edge of lag has passed, and one check samples just before that edge to confirm the old value is still held.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
   localparam int WORD_BITS = 32;
   localparam int MAX_WORDS = 8;

   typedef logic [WORD_BITS-1:0] word_t;

   // Register group order inside one bank; software depends on this order.
   typedef enum logic [1:0] {
      GRP_STATUS = 2'd0,
      GRP_MASK   = 2'd1,
      GRP_SET    = 2'd2,
      GRP_CLR    = 2'd3
   } grp_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_bank_pkg::*;
#(
   parameter int N_WORDS = 4,
   parameter int ADDR_W  = 8,
   parameter int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output grp_e              grp_o,
   output logic [WSEL_W-1:0] word_o,
   output logic              in_range_o
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx, quo, rem;
   logic             unused_bits;

   assign idx        = addr_i[ADDR_W-1:2];
   assign quo        = idx / IDX_W'(N_WORDS);
   assign rem        = idx % IDX_W'(N_WORDS);
   assign in_range_o = {1'b0, idx} < (IDX_W+1)'(4 * N_WORDS);
   assign grp_o      = grp_e'(quo[1:0]);
   assign word_o     = rem[WSEL_W-1:0];
   assign unused_bits = ^{quo, rem, addr_i[1:0]};
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
   import irq_bank_pkg::*;
#(
   parameter int N_WORDS = 4,
   parameter int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic [N_WORDS*WORD_BITS-1:0] src_i,
   input  logic                         upd_i,
   input  logic                         upd_set_i,
   input  logic [WSEL_W-1:0]            upd_word_i,
   input  word_t                        upd_data_i,
   output logic [N_WORDS*WORD_BITS-1:0] mask_o,
   output logic                         irq_o
);
   logic [N_WORDS-1:0][WORD_BITS-1:0] mask_q;
   logic [N_WORDS*WORD_BITS-1:0]      pend;
   logic                              irq_q;

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic hit;
      assign hit = upd_i && (upd_word_i == WSEL_W'(w));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mask_q[w] <= '1;
         end else if (hit) begin
            if (upd_set_i) mask_q[w] <= mask_q[w] | upd_data_i;
            else           mask_q[w] <= mask_q[w] & ~upd_data_i;
         end
      end

      // R3
      set_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hit && upd_set_i) |=> ((mask_q[w] & $past(upd_data_i)) == $past(upd_data_i)));
      // R4
      clr_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hit && !upd_set_i) |=> ((mask_q[w] & $past(upd_data_i)) == '0));
   end

   assign mask_o = mask_q;
   assign pend   = src_i & ~mask_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |pend;
   end
   assign irq_o = irq_q;

   // R1
   all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&mask_o) |=> !irq_o);
   // R6
   pend_raises_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((src_i & ~mask_o) != '0) |=> irq_o);
endmodule

// File: rtl/irq_banked_aggregator.sv
module irq_banked_aggregator
   import irq_bank_pkg::*;
#(
   parameter int N_WORDS = 4,
   parameter int N_CPUS  = 2,
   parameter int ADDR_W  = 8,
   parameter int CPU_W   = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         bus_valid_i,
   input  logic                         bus_write_i,
   input  logic [CPU_W-1:0]             bus_cpu_i,
   input  logic [ADDR_W-1:0]            bus_addr_i,
   input  logic [WORD_BITS-1:0]         bus_wdata_i,
   output logic                         bus_rvalid_o,
   output logic [WORD_BITS-1:0]         bus_rdata_o,
   input  logic [N_WORDS*WORD_BITS-1:0] src_i,
   output logic [N_CPUS-1:0]            cpu_irq_o
);
   localparam int WSEL_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
   localparam int MIN_ADDRW = $clog2(16 * N_WORDS);

   if (N_WORDS < 1 || N_WORDS > MAX_WORDS) begin : g_bad_words
      $error("N_WORDS must lie in 1..8");
   end
   if (N_CPUS < 1) begin : g_bad_cpus
      $error("N_CPUS must be at least 1");
   end
   if (ADDR_W < MIN_ADDRW || ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too narrow for the bank");
   end

   grp_e                grp;
   logic [WSEL_W-1:0]   word;
   logic                in_range, cpu_ok, rd_req, wr_req, upd;
   word_t               rdata_d, rdata_q;
   logic                rvalid_q;
   logic [N_CPUS-1:0][N_WORDS*WORD_BITS-1:0] mask_all;

   irq_addr_decode #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W), .WSEL_W(WSEL_W)) u_dec (
      .addr_i     (bus_addr_i),
      .grp_o      (grp),
      .word_o     (word),
      .in_range_o (in_range)
   );

   assign cpu_ok = {1'b0, bus_cpu_i} < (CPU_W+1)'(N_CPUS);
   assign rd_req = bus_valid_i && !bus_write_i;
   assign wr_req = bus_valid_i && bus_write_i;
   assign upd    = wr_req && in_range && cpu_ok && (grp == GRP_SET || grp == GRP_CLR);

   for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
      logic sel;
      assign sel = (bus_cpu_i == CPU_W'(c));

      irq_mask_bank #(.N_WORDS(N_WORDS), .WSEL_W(WSEL_W)) u_bank (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .src_i      (src_i),
         .upd_i      (upd && sel),
         .upd_set_i  (grp == GRP_SET),
         .upd_word_i (word),
         .upd_data_i (bus_wdata_i),
         .mask_o     (mask_all[c]),
         .irq_o      (cpu_irq_o[c])
      );
   end

   always_comb begin
      rdata_d = '0;
      if (in_range && cpu_ok) begin
         unique case (grp)
            GRP_STATUS: rdata_d = src_i[word*WORD_BITS +: WORD_BITS];
            GRP_MASK:   rdata_d = mask_all[bus_cpu_i][word*WORD_BITS +: WORD_BITS];
            default:    rdata_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= rd_req;
         if (rd_req) rdata_q <= rdata_d;
      end
   end

   assign bus_rvalid_o = rvalid_q;
   assign bus_rdata_o  = rdata_q;

   // R9
   rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req |=> bus_rvalid_o);
   // R9
   no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_req |=> !bus_rvalid_o);
   // R10
   oor_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req && !(in_range && cpu_ok)) |=> (bus_rdata_o == '0));
   // R10
   oor_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req && !(in_range && cpu_ok)) |=> $stable(mask_all));
   // R8
   ro_group_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req && (grp == GRP_STATUS || grp == GRP_MASK)) |=> $stable(mask_all));
endmodule

// File: tb/sim_irq_banked_aggregator.sv
`timescale 1ns/1ps
module sim_irq_banked_aggregator;
   localparam int NW = 4;
   localparam int NC = 2;
   localparam int AW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bv = 1'b0, bw = 1'b0;
   logic [0:0]      bcpu = '0;
   logic [AW-1:0]   baddr = '0;
   logic [31:0]     bwd = '0;
   logic            rvalid;
   logic [31:0]     rdata;
   logic [NW*32-1:0] src = '0;
   logic [NC-1:0]   irq;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [31:0] mdl [NC][NW];
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   irq_banked_aggregator #(.N_WORDS(NW), .N_CPUS(NC), .ADDR_W(AW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bv), .bus_write_i(bw),
      .bus_cpu_i(bcpu), .bus_addr_i(baddr), .bus_wdata_i(bwd),
      .bus_rvalid_o(rvalid), .bus_rdata_o(rdata), .src_i(src), .cpu_irq_o(irq));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int offs(int grp, int w);
      return (grp * NW + w) * 4;
   endfunction

   // monitor: pops expected read data when a response is due
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) check("R9 unexpected response", 32'd1, 32'd0);
         else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic wr_raw(int cpu, int addr, logic [31:0] d);
      @(negedge clk);
      bv = 1; bw = 1; bcpu = cpu[0]; baddr = addr[AW-1:0]; bwd = d;
      @(negedge clk);
      bv = 0; bw = 0;
   endtask

   task automatic wr(int cpu, int grp, int w, logic [31:0] d);
      wr_raw(cpu, offs(grp, w), d);
      if (grp == 2) mdl[cpu][w] = mdl[cpu][w] | d;
      if (grp == 3) mdl[cpu][w] = mdl[cpu][w] & ~d;
   endtask

   task automatic rd_raw(int cpu, int addr, logic [31:0] exp, string tag);
      @(negedge clk);
      bv = 1; bw = 0; bcpu = cpu[0]; baddr = addr[AW-1:0];
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bv = 0;
      check("R9 rvalid one cycle after request", {31'd0, rvalid}, 32'd1);
   endtask

   task automatic rd(int cpu, int grp, int w, logic [31:0] exp, string tag);
      rd_raw(cpu, offs(grp, w), exp, tag);
   endtask

   function automatic logic [NC-1:0] exp_irq();
      logic [NC-1:0] r = '0;
      for (int c = 0; c < NC; c++)
         for (int w = 0; w < NW; w++)
            if ((src[w*32 +: 32] & ~mdl[c][w]) != 0) r[c] = 1'b1;
      return r;
   endfunction

   task automatic chk_irq(string tag);
      @(negedge clk);
      check(tag, {30'd0, irq}, {30'd0, exp_irq()});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      check("watchdog expired", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) mdl[c][w] = '1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq after reset", {30'd0, irq}, 32'd0);
      check("R1 rvalid after reset", {31'd0, rvalid}, 32'd0);
      rst_n = 1;
      @(negedge clk);
      for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++)
         rd(c, 1, w, 32'hFFFF_FFFF, "R1 R2 mask all ones after reset");

      // R5 status follows live levels
      src = {32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0020, 32'h1234_5678};
      for (int w = 0; w < NW; w++) rd(0, 0, w, src[w*32 +: 32], "R5 R2 status word");
      chk_irq("R1 masked sources give no irq");
      src[32 +: 32] = 32'hA5A5_0001;
      rd(1, 0, 1, 32'hA5A5_0001, "R5 status tracks change");

      // R4 enable port, R6 lag, R7 independence
      src = '0;
      src[37] = 1'b1;
      wr(0, 3, 1, 32'h0000_0020);
      rd(0, 1, 1, 32'hFFFF_FFDF, "R4 clear port unmasks bit");
      rd(1, 1, 1, 32'hFFFF_FFFF, "R7 other bank untouched");
      chk_irq("R6 R7 irq only on enabled cpu");
      check("R6 cpu0 irq high", {31'd0, irq[0]}, 32'd1);
      check("R7 cpu1 irq low", {31'd0, irq[1]}, 32'd0);

      // R6 one-cycle lag on source change
      @(negedge clk);
      src[37] = 1'b0;
      #1 check("R6 irq holds before edge", {31'd0, irq[0]}, 32'd1);
      chk_irq("R6 irq drops one edge later");
      src[37] = 1'b1;
      chk_irq("R6 irq rises again");

      // R3 / R4 zero bits leave mask alone
      wr(0, 2, 1, 32'h0000_0000);
      rd(0, 1, 1, 32'hFFFF_FFDF, "R3 zero set data no change");
      wr(0, 3, 1, 32'h0000_0000);
      rd(0, 1, 1, 32'hFFFF_FFDF, "R4 zero clear data no change");
      wr(0, 2, 1, 32'h0000_0020);
      rd(0, 1, 1, 32'hFFFF_FFFF, "R3 set port masks bit");
      chk_irq("R3 R6 irq drops after masking");

      // R7 second bank, last word
      src[3*32 +: 32] = 32'h8000_0000;
      wr(1, 3, 3, 32'hF000_0000);
      rd(1, 1, 3, 32'h0FFF_FFFF, "R7 R2 cpu1 word3 mask");
      rd(0, 1, 3, 32'hFFFF_FFFF, "R7 cpu0 word3 untouched");
      chk_irq("R7 irq on cpu1 only");

      // R8 read-only groups and write-only ports
      wr_raw(1, offs(1, 3), 32'h0000_0000);
      wr_raw(1, offs(0, 3), 32'h0000_0000);
      rd(1, 1, 3, 32'h0FFF_FFFF, "R8 writes to status/mask ignored");
      rd(1, 2, 3, 32'h0000_0000, "R8 set group reads zero");
      rd(1, 3, 3, 32'h0000_0000, "R8 clear group reads zero");

      // R10 out of range
      wr_raw(0, 16 * NW, 32'hFFFF_FFFF);
      wr_raw(0, 255, 32'hFFFF_FFFF);
      for (int w = 0; w < NW; w++) rd(0, 1, w, mdl[0][w], "R10 masks unchanged");
      rd_raw(0, 16 * NW, 32'h0, "R10 out-of-range read zero");
      chk_irq("R10 irq unchanged");

      // R2 misaligned low bits ignored
      rd_raw(1, offs(1, 3) + 3, 32'h0FFF_FFFF, "R2 low address bits ignored");

      repeat (3) @(negedge clk);
      check("R9 all responses seen", exp_q.size(), 32'd0);
      finish_run();
   end
endmodule